// File: doc/BRIEF.md
# Virtual CPU maintenance interrupt generator

This block serves a virtual interrupt controller that hosts several physical CPU interfaces. For each interface it scans that CPU's list registers, the slots that hold virtual interrupts for a guest. It counts three kinds of entry. An EOI entry is an entry that has retired and asked for end-of-interrupt notification. A valid entry is any entry that is not in the invalid state. A pending entry is an entry whose state is exactly pending.

From these counts, the hypervisor control enables, the end-of-interrupt counter and the guest's two group enables, the block builds an eight-bit maintenance status word. The status word is combinational. A registered, level-sensitive maintenance interrupt goes high when the global enable is set and the status word is nonzero.

The list register contents arrive as separate fields: a 2-bit state, a hardware-link flag and an end-of-interrupt request flag per slot. The hypervisor control arrives as an eight-bit enable byte and a 5-bit counter per CPU. The register bus is outside this block, and so is the logic that writes the list registers.

Top module: `vmaint_gen`

## Requirements
- R1: Status bit 0 is set when at least one list register of that CPU has state 0 (invalid), its hardware-link flag clear and its EOI request flag set. State encoding: 0 invalid, 1 pending, 2 active, 3 pending-and-active.
- R2: Status bit 1 (underflow) is set when control bit 1 is set and fewer than two of the CPU's list registers have a state other than 0.
- R3: Status bit 3 (nothing pending) is set when control bit 3 is set and no list register has state exactly 1. State 3 does not count as pending.
- R4: Status bit 2 (entry not present) is set when control bit 2 is set and the 5-bit EOI counter of that CPU is nonzero.
- R5: Status bits 4 to 7 come from the guest group enables (vgrp_en bit 0 is group 0, bit 1 is group 1), each bit with its own control enable:
  - bit 4 is group 0 enabled, gated by control bit 4;
  - bit 5 is group 0 disabled, gated by control bit 5;
  - bit 6 is group 1 enabled, gated by control bit 6;
  - bit 7 is group 1 disabled, gated by control bit 7.
- R6: The maintenance interrupt of a CPU is high in the cycle after a clock edge exactly when, at that edge, control bit 0 (global enable) was set and that CPU's status word was nonzero.
- R7: Each CPU's status word and interrupt depend only on that CPU's own list registers, control byte, counter and group enables.
- R8: While reset is asserted, every maintenance interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lr_state | input | NUM_CPU*NUM_LR*2 | State field of each list register, CPU-major |
| lr_hw | input | NUM_CPU*NUM_LR | Hardware-linked flag of each list register |
| lr_eoi | input | NUM_CPU*NUM_LR | EOI request flag of each list register |
| hyp_ctl | input | NUM_CPU*8 | Per CPU: bit 0 global enable, bits 1 to 7 status enables |
| eoi_cnt | input | NUM_CPU*CNT_W | Per-CPU end-of-interrupt counter |
| vgrp_en | input | NUM_CPU*2 | Per-CPU guest group 0 and group 1 enables |
| status | output | NUM_CPU*8 | Per-CPU maintenance status word |
| maint_irq | output | NUM_CPU | Per-CPU registered maintenance interrupt |

## Verification
The bench sweeps every combination of state, link flag and EOI request over two list registers. It crosses this with four control patterns and all group-enable settings, and gives the second CPU a different input set in the same cycles.

This reaches several corner cases, each with a visible failure mode:
- An entry in state 3 treated as pending would clear the nothing-pending bit when it should stay set.
- A hardware-linked or non-invalid entry counted as an EOI entry would raise bit 0 when it should stay clear.
- An off-by-one in the underflow compare would miss the case of exactly one valid entry.
- A swapped CPU index would show one CPU's status on the other.
- A missing global-enable gate would raise the interrupt when control bit 0 is clear.

// File: rtl/vmaint_gen.sv
module vmaint_gen #(
  parameter int NUM_CPU = 2,
  parameter int NUM_LR  = 4,
  parameter int CNT_W   = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CPU*NUM_LR*2-1:0] lr_state,
  input  logic [NUM_CPU*NUM_LR-1:0]   lr_hw,
  input  logic [NUM_CPU*NUM_LR-1:0]   lr_eoi,
  input  logic [NUM_CPU*8-1:0]        hyp_ctl,
  input  logic [NUM_CPU*CNT_W-1:0]    eoi_cnt,
  input  logic [NUM_CPU*2-1:0]        vgrp_en,
  output logic [NUM_CPU*8-1:0]        status,
  output logic [NUM_CPU-1:0]          maint_irq
);

  localparam int NW = $clog2(NUM_LR + 1);
  localparam logic [1:0] ST_INVALID = 2'd0;
  localparam logic [1:0] ST_PENDING = 2'd1;

  logic [NUM_CPU-1:0] irq_d;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NW-1:0] n_valid, n_pend;
    logic          any_eoi;
    logic [7:0]    ctl;
    logic          g0, g1;
    logic          st_eoi, st_uf, st_lrnp, st_np;
    logic          st_g0e, st_g0d, st_g1e, st_g1d;

    always_comb begin
      n_valid = '0;
      n_pend  = '0;
      any_eoi = 1'b0;
      for (int i = 0; i < NUM_LR; i++) begin
        if (lr_state[(c*NUM_LR+i)*2 +: 2] != ST_INVALID)
          n_valid = n_valid + NW'(1);
        if (lr_state[(c*NUM_LR+i)*2 +: 2] == ST_PENDING)
          n_pend = n_pend + NW'(1);
        if (lr_state[(c*NUM_LR+i)*2 +: 2] == ST_INVALID &&
            !lr_hw[c*NUM_LR+i] && lr_eoi[c*NUM_LR+i])
          any_eoi = 1'b1;
      end
    end

    assign ctl = hyp_ctl[c*8 +: 8];
    assign g0  = vgrp_en[c*2];
    assign g1  = vgrp_en[c*2+1];

    assign st_eoi  = any_eoi;
    assign st_uf   = ctl[1] && (n_valid <= NW'(1));
    assign st_lrnp = ctl[2] && (eoi_cnt[c*CNT_W +: CNT_W] != '0);
    assign st_np   = ctl[3] && (n_pend == '0);
    assign st_g0e  = ctl[4] &&  g0;
    assign st_g0d  = ctl[5] && !g0;
    assign st_g1e  = ctl[6] &&  g1;
    assign st_g1d  = ctl[7] && !g1;

    assign status[c*8 +: 8] = {st_g1d, st_g1e, st_g0d, st_g0e,
                               st_np, st_lrnp, st_uf, st_eoi};
    assign irq_d[c] = ctl[0] && (status[c*8 +: 8] != 8'h00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) maint_irq <= '0;
    else        maint_irq <= irq_d;
  end

endmodule

module vmaint_gen_chk #(
  parameter int NUM_CPU = 2,
  parameter int NUM_LR  = 4,
  parameter int CNT_W   = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_CPU*NUM_LR*2-1:0] lr_state,
  input logic [NUM_CPU*NUM_LR-1:0]   lr_hw,
  input logic [NUM_CPU*NUM_LR-1:0]   lr_eoi,
  input logic [NUM_CPU*8-1:0]        hyp_ctl,
  input logic [NUM_CPU*CNT_W-1:0]    eoi_cnt,
  input logic [NUM_CPU*2-1:0]        vgrp_en,
  input logic [NUM_CPU*8-1:0]        status,
  input logic [NUM_CPU-1:0]          maint_irq
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_comb begin
    if (!rst_n) p_reset_quiet_r8 : assert (maint_irq == '0);
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    p_irq_follows_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> maint_irq[c] == $past(hyp_ctl[c*8] && status[c*8 +: 8] != 8'h00));

    p_grp0_excl_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      !(status[c*8+4] && status[c*8+5]));

    p_grp1_excl_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      !(status[c*8+6] && status[c*8+7]));

    p_lrnp_needs_cnt_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      status[c*8+2] |-> (hyp_ctl[c*8+2] && eoi_cnt[c*CNT_W +: CNT_W] != '0));

    p_uf_enable_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      status[c*8+1] |-> hyp_ctl[c*8+1]);

    p_np_enable_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      status[c*8+3] |-> hyp_ctl[c*8+3]);

    p_eoi_needs_flag_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      status[c*8] |-> (lr_eoi[c*NUM_LR +: NUM_LR] != '0));
  end

endmodule

bind vmaint_gen vmaint_gen_chk #(.NUM_CPU(NUM_CPU), .NUM_LR(NUM_LR), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/vmaint_gen_tb_top.sv
`timescale 1ns/1ps
module vmaint_gen_tb_top;
  localparam int NC = 2;
  localparam int NL = 2;
  localparam int CW = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NC*NL*2-1:0] lr_state = '0;
  logic [NC*NL-1:0]   lr_hw = '0;
  logic [NC*NL-1:0]   lr_eoi = '0;
  logic [NC*8-1:0]    hyp_ctl = '0;
  logic [NC*CW-1:0]   eoi_cnt = '0;
  logic [NC*2-1:0]    vgrp_en = '0;
  logic [NC*8-1:0]    status;
  logic [NC-1:0]      maint_irq;

  int n_chk = 0;
  int n_fail = 0;
  string tags[8] = '{"R1", "R2", "R4", "R3", "R5", "R5", "R5", "R5"};

  always #2.5 clk = ~clk;

  vmaint_gen #(.NUM_CPU(NC), .NUM_LR(NL), .CNT_W(CW)) dut_i (.*);

  // code per LR: [1:0] state, [2] hw-link, [3] eoi request
  task automatic set_cpu(int c, logic [7:0] codes, logic [7:0] ctl,
                         logic [4:0] cnt, logic [1:0] vg);
    for (int i = 0; i < NL; i++) begin
      lr_state[(c*NL+i)*2 +: 2] = codes[i*4 +: 2];
      lr_hw[c*NL+i]             = codes[i*4+2];
      lr_eoi[c*NL+i]            = codes[i*4+3];
    end
    hyp_ctl[c*8 +: 8]   = ctl;
    eoi_cnt[c*CW +: CW] = cnt;
    vgrp_en[c*2 +: 2]   = vg;
  endtask

  function automatic logic [7:0] exp_st(logic [7:0] codes, logic [7:0] ctl,
                                        logic [4:0] cnt, logic [1:0] vg);
    int nv = 0, np = 0, ne = 0;
    logic [7:0] s;
    for (int i = 0; i < NL; i++) begin
      int st = int'(codes[i*4 +: 2]);
      if (st != 0) nv++;
      if (st == 1) np++;
      if (st == 0 && codes[i*4+2] == 1'b0 && codes[i*4+3] == 1'b1) ne++;
    end
    s[0] = ne > 0;
    s[1] = ctl[1] && nv < 2;
    s[2] = ctl[2] && cnt != 0;
    s[3] = ctl[3] && np == 0;
    s[4] = ctl[4] && vg[0];
    s[5] = ctl[5] && !vg[0];
    s[6] = ctl[6] && vg[1];
    s[7] = ctl[7] && !vg[1];
    return s;
  endfunction

  function automatic logic [7:0] pat_ctl(int k);
    case (k)
      0: return 8'hFF;
      1: return 8'hFF;
      2: return 8'h0E;
      default: return 8'hF1;
    endcase
  endfunction

  function automatic logic [4:0] pat_cnt(int k);
    case (k)
      0: return 5'd0;
      1: return 5'd5;
      2: return 5'd1;
      default: return 5'd31;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    // R8: inputs that would raise the line, held in reset
    set_cpu(0, 8'h00, 8'hFF, 5'd3, 2'b00);
    set_cpu(1, 8'h00, 8'hFF, 5'd3, 2'b11);
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset irq", int'(maint_irq), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < 4; k++) begin
      for (int v = 0; v < 4; v++) begin
        for (int code = 0; code < 256; code++) begin
          logic [7:0] c0, c1, e0, e1, ctl0, ctl1;
          logic [4:0] n0, n1;
          logic [1:0] vg0, vg1;
          c0 = 8'(code);
          c1 = 8'(code) ^ 8'hA5;
          ctl0 = pat_ctl(k);
          ctl1 = pat_ctl((k + 1) % 4);
          n0 = pat_cnt(k);
          n1 = pat_cnt((k + 1) % 4);
          vg0 = 2'(v);
          vg1 = ~2'(v);
          e0 = exp_st(c0, ctl0, n0, vg0);
          e1 = exp_st(c1, ctl1, n1, vg1);
          @(negedge clk);
          set_cpu(0, c0, ctl0, n0, vg0);
          set_cpu(1, c1, ctl1, n1, vg1);
          @(posedge clk);
          #1;
          for (int b = 0; b < 8; b++) begin
            check({tags[b], " cpu0 status bit"}, int'(status[b]), int'(e0[b]));
            check({tags[b], " R7 cpu1 status bit"}, int'(status[8+b]), int'(e1[b]));
          end
          check("R6 cpu0 irq", int'(maint_irq[0]), int'(ctl0[0] && e0 != 0));
          check("R7 R6 cpu1 irq", int'(maint_irq[1]), int'(ctl1[0] && e1 != 0));
        end
      end
    end

    // R6: the line drops one cycle after the global enable is cleared
    @(negedge clk);
    set_cpu(0, 8'h00, 8'hFF, 5'd1, 2'b01);
    @(posedge clk);
    #1;
    check("R6 irq raised", int'(maint_irq[0]), 1);
    @(negedge clk);
    hyp_ctl[0] = 1'b0;
    #1;
    check("R6 irq holds before edge", int'(maint_irq[0]), 1);
    @(posedge clk);
    #1;
    check("R6 irq dropped", int'(maint_irq[0]), 0);
    report();
  end
endmodule